// File: doc/BRIEF.md
# Mode-Based Token Switch Actor

This block is a hardware dataflow actor. It steers each data token from one input stream to one of two output streams, a "true" side and a "false" side. The side is picked by a Boolean control token, which arrives on its own stream. Every stream is a valid/ready port: a token moves when valid and ready are both high at a rising clock edge.

The actor is a three-state mode machine. In the control mode it takes exactly one control token and writes nothing. The value of that token picks the next mode. In the true mode and in the false mode it takes exactly one data token and writes it unchanged to the matching output. It then goes back to the control mode. A firing takes one clock cycle. The actor fires only when the current mode's input token is present and, in a data mode, the selected output can accept it. Otherwise the actor holds its mode. The current mode is shown on a status output.

Top module: `swa_switch_actor`

## Requirements
- R1: While reset is asserted and right after it is released, mode_o is 2'b00 (control mode), both out_t_valid and out_f_valid are 0, and dat_ready is 0.
- R2: In control mode, ctl_ready is 1, dat_ready is 0 and neither output is valid, whatever dat_valid is. A data token offered in this mode is not consumed and the mode does not change.
- R3: A control firing (ctl_valid and ctl_ready both high at an edge) sets mode_o to 2'b01 (true mode) when ctl_bit is 1, and to 2'b10 (false mode) when ctl_bit is 0, from the next cycle on.
- R4: In true mode, out_t_valid equals dat_valid, out_t_data equals dat_data, dat_ready equals out_t_ready, and out_f_valid and ctl_ready are 0.
- R5: In false mode, out_f_valid equals dat_valid, out_f_data equals dat_data, dat_ready equals out_f_ready, and out_t_valid and ctl_ready are 0.
- R6: After a data firing in true or false mode, mode_o is 2'b00 on the next cycle.
- R7: In a data mode the actor stalls when dat_valid is 0 or the selected output's ready is 0. The mode is then unchanged and no token is consumed. The ready of the unselected output has no effect.
- R8: A control token offered during a data mode is not consumed (ctl_ready is 0). It does not change the mode, and it is taken once the actor is back in control mode.
- R9: At most one firing happens per cycle, and the two output valids are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_valid | input | 1 | Control token present |
| ctl_bit | input | 1 | Control token value (1 selects true side) |
| ctl_ready | output | 1 | Actor accepts a control token |
| dat_valid | input | 1 | Data token present |
| dat_data | input | DATA_W | Data token payload |
| dat_ready | output | 1 | Actor accepts a data token |
| out_t_valid | output | 1 | Token on the true output |
| out_t_data | output | DATA_W | True output payload |
| out_t_ready | input | 1 | True output can accept (not full) |
| out_f_valid | output | 1 | Token on the false output |
| out_f_data | output | DATA_W | False output payload |
| out_f_ready | input | 1 | False output can accept (not full) |
| mode_o | output | 2 | Current mode: 00 control, 01 true, 10 false |

## Verification
The hardest case to reach from the ports is a control token that is waiting while the actor sits in a data mode whose selected output is full. That token must be neither consumed nor allowed to change the mode. The bench first steers the actor into a data mode. It then holds the chosen output's ready low and offers a control token of the opposite value. It also raises the unselected output's ready and checks that the mode stays put over several cycles. Finally it releases the output and checks that the waiting control token is taken only after the data firing has returned the actor to control mode.

// File: rtl/swa_pkg.sv
package swa_pkg;

  typedef enum logic [1:0] {
    MODE_CTRL  = 2'b00,
    MODE_TRUE  = 2'b01,
    MODE_FALSE = 2'b10
  } swa_mode_e;

  localparam int MODE_W = 2;

  // Mode selected by a control token value.
  function automatic swa_mode_e mode_from_token(input logic tok);
    return tok ? MODE_TRUE : MODE_FALSE;
  endfunction

  // Next mode after one cycle, given the firings of that cycle.
  function automatic swa_mode_e mode_step(input swa_mode_e cur, input logic ctl_fire,
                                          input logic dat_fire, input logic tok);
    swa_mode_e nxt;
    nxt = cur;
    if (ctl_fire)      nxt = mode_from_token(tok);
    else if (dat_fire) nxt = MODE_CTRL;
    return nxt;
  endfunction

endpackage

// File: rtl/swa_enable.sv
module swa_enable
  import swa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  swa_mode_e mode,
  input  logic      ctl_valid,
  input  logic      dat_valid,
  input  logic      out_t_ready,
  input  logic      out_f_ready,
  output logic      ctl_ready,
  output logic      dat_ready,
  output logic      ctl_fire,
  output logic      dat_fire
);

  logic mode_is_ctrl;
  logic mode_is_true;
  logic mode_is_false;

  always_comb begin
    mode_is_ctrl  = (mode == MODE_CTRL);
    mode_is_true  = (mode == MODE_TRUE);
    mode_is_false = (mode == MODE_FALSE);
    ctl_ready     = mode_is_ctrl;
    dat_ready     = (mode_is_true & out_t_ready) | (mode_is_false & out_f_ready);
    ctl_fire      = ctl_valid & ctl_ready;
    dat_fire      = dat_valid & dat_ready;
  end

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_fire, dat_fire})); // R9

  AST_NO_DATA_IN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CTRL) |-> !dat_ready); // R2

endmodule

// File: rtl/swa_mode_fsm.sv
module swa_mode_fsm
  import swa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_fire,
  input  logic      dat_fire,
  input  logic      ctl_bit,
  output swa_mode_e mode
);

  swa_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_CTRL;
    else        mode_q <= mode_step(mode_q, ctl_fire, dat_fire, ctl_bit);
  end

  assign mode = mode_q;

  AST_CTRL_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && ctl_bit) |=> (mode_q == MODE_TRUE)); // R3

  AST_CTRL_SELECTS_F: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && !ctl_bit) |=> (mode_q == MODE_FALSE)); // R3

  AST_DATA_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fire |=> (mode_q == MODE_CTRL)); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_fire && !dat_fire) |=> $stable(mode_q)); // R7

  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b11)); // R9

endmodule

// File: rtl/swa_route.sv
module swa_route
  import swa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  swa_mode_e         mode,
  input  logic              dat_valid,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_ready,
  input  logic              out_t_ready,
  input  logic              out_f_ready,
  output logic              out_t_valid,
  output logic [DATA_W-1:0] out_t_data,
  output logic              out_f_valid,
  output logic [DATA_W-1:0] out_f_data
);

  always_comb begin
    out_t_valid = dat_valid & (mode == MODE_TRUE);
    out_f_valid = dat_valid & (mode == MODE_FALSE);
    out_t_data  = dat_data;
    out_f_data  = dat_data;
  end

  AST_EXCL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_t_valid && out_f_valid)); // R9

  AST_QUIET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CTRL) |-> (!out_t_valid && !out_f_valid)); // R2

  AST_TRUE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t_valid && out_t_ready) |-> dat_ready); // R4

  AST_FALSE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_f_valid && out_f_ready) |-> dat_ready); // R5

endmodule

// File: rtl/swa_switch_actor.sv
module swa_switch_actor
  import swa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic              ctl_bit,
  output logic              ctl_ready,
  input  logic              dat_valid,
  input  logic [DATA_W-1:0] dat_data,
  output logic              dat_ready,
  output logic              out_t_valid,
  output logic [DATA_W-1:0] out_t_data,
  input  logic              out_t_ready,
  output logic              out_f_valid,
  output logic [DATA_W-1:0] out_f_data,
  input  logic              out_f_ready,
  output logic [1:0]        mode_o
);

  swa_mode_e mode;
  logic      ctl_fire;
  logic      dat_fire;

  swa_enable u_enable (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .ctl_valid   (ctl_valid),
    .dat_valid   (dat_valid),
    .out_t_ready (out_t_ready),
    .out_f_ready (out_f_ready),
    .ctl_ready   (ctl_ready),
    .dat_ready   (dat_ready),
    .ctl_fire    (ctl_fire),
    .dat_fire    (dat_fire)
  );

  swa_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_fire (ctl_fire),
    .dat_fire (dat_fire),
    .ctl_bit  (ctl_bit),
    .mode     (mode)
  );

  swa_route #(.DATA_W(DATA_W)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .dat_valid   (dat_valid),
    .dat_data    (dat_data),
    .dat_ready   (dat_ready),
    .out_t_ready (out_t_ready),
    .out_f_ready (out_f_ready),
    .out_t_valid (out_t_valid),
    .out_t_data  (out_t_data),
    .out_f_valid (out_f_valid),
    .out_f_data  (out_f_data)
  );

  assign mode_o = mode;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (mode_o == 2'b00 && !out_t_valid && !out_f_valid)); // R1

endmodule

// File: tb/swa_switch_actor_bench.sv
module swa_switch_actor_bench;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_valid = 1'b0;
  logic              ctl_bit = 1'b0;
  logic              ctl_ready;
  logic              dat_valid = 1'b0;
  logic [DATA_W-1:0] dat_data = '0;
  logic              dat_ready;
  logic              out_t_valid;
  logic [DATA_W-1:0] out_t_data;
  logic              out_t_ready = 1'b0;
  logic              out_f_valid;
  logic [DATA_W-1:0] out_f_data;
  logic              out_f_ready = 1'b0;
  logic [1:0]        mode_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  swa_switch_actor #(.DATA_W(DATA_W)) u_swa_switch_actor (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_bit(ctl_bit), .ctl_ready(ctl_ready),
    .dat_valid(dat_valid), .dat_data(dat_data), .dat_ready(dat_ready),
    .out_t_valid(out_t_valid), .out_t_data(out_t_data), .out_t_ready(out_t_ready),
    .out_f_valid(out_f_valid), .out_f_data(out_f_data), .out_f_ready(out_f_ready),
    .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, sample combinational outputs 5 ns later.
  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  task automatic idle_inputs();
    ctl_valid = 1'b0; dat_valid = 1'b0; out_t_ready = 1'b0; out_f_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    dat_valid = 1'b1;
    settle();
    check("R1 mode in reset", mode_o, 2'b00);
    check("R1 t valid in reset", out_t_valid, 0);
    check("R1 f valid in reset", out_f_valid, 0);
    check("R1 dat_ready in reset", dat_ready, 0);
    rst_n = 1'b1;
    dat_valid = 1'b0;
    settle();
    check("R1 mode after reset", mode_o, 2'b00);
  endtask

  // Control firing with value tok; checks R2 behaviour and R3 next mode.
  task automatic t_ctl(input logic tok);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_bit = tok; dat_valid = 1'b1;
    #5;
    check("R2 ctl_ready in ctrl", ctl_ready, 1);
    check("R2 dat_ready in ctrl", dat_ready, 0);
    check("R2 outputs quiet", {out_t_valid, out_f_valid}, 0);
    @(negedge clk);
    ctl_valid = 1'b0; dat_valid = 1'b0;
    #5;
    check("R3 mode after control", mode_o, tok ? 2'b01 : 2'b10);
  endtask

  // Data firing in the current data mode; expects the given side.
  task automatic t_dat(input logic side_true, input logic [DATA_W-1:0] val);
    @(negedge clk);
    dat_valid = 1'b1; dat_data = val; out_t_ready = 1'b1; out_f_ready = 1'b1;
    #5;
    if (side_true) begin
      check("R4 t valid", out_t_valid, 1);
      check("R4 t data", out_t_data, val);
      check("R4 f quiet", out_f_valid, 0);
    end else begin
      check("R5 f valid", out_f_valid, 1);
      check("R5 f data", out_f_data, val);
      check("R5 t quiet", out_t_valid, 0);
    end
    check("R4/R5 dat_ready", dat_ready, 1);
    check("R8 ctl_ready low in data mode", ctl_ready, 0);
    @(negedge clk);
    idle_inputs();
    #5;
    check("R6 mode back to ctrl", mode_o, 2'b00);
  endtask

  // Data offered in control mode is not taken.
  task automatic t_data_in_ctrl();
    @(negedge clk);
    dat_valid = 1'b1; out_t_ready = 1'b1; out_f_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #5;
      check("R2 dat_ready low in ctrl", dat_ready, 0);
      @(negedge clk);
    end
    #5;
    check("R2 mode kept ctrl", mode_o, 2'b00);
    idle_inputs();
  endtask

  // Stall in true mode: output full, other side ready, opposite control token waiting.
  task automatic t_stall_and_pending_ctl();
    t_ctl(1'b1);
    @(negedge clk);
    dat_valid = 1'b1; dat_data = 16'hBEEF; out_t_ready = 1'b0; out_f_ready = 1'b1;
    ctl_valid = 1'b1; ctl_bit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #5;
      check("R7 dat_ready low when full", dat_ready, 0);
      check("R8 ctl_ready low while stalled", ctl_ready, 0);
      check("R7 t valid held", out_t_valid, 1);
      @(negedge clk);
    end
    #5;
    check("R7 R8 mode held true", mode_o, 2'b01);
    dat_valid = 1'b0; out_t_ready = 1'b1;
    @(negedge clk);
    #5;
    check("R7 mode held without data", mode_o, 2'b01);
    @(negedge clk);
    dat_valid = 1'b1;
    #5;
    check("R4 fire after release", dat_ready, 1);
    check("R4 data after stall", out_t_data, 16'hBEEF);
    @(negedge clk);
    dat_valid = 1'b0;
    #5;
    check("R6 ctrl after stalled fire", mode_o, 2'b00);
    check("R8 pending ctl now accepted", ctl_ready, 1);
    @(negedge clk);
    ctl_valid = 1'b0;
    #5;
    check("R8 pending token sets false", mode_o, 2'b10);
    t_dat(1'b0, 16'h1234);
  endtask

  // Pseudo-random token stream.
  task automatic t_sequence();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      logic b;
      b = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      t_ctl(b);
      t_dat(b, {8'(i), lfsr});
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_data_in_ctrl();
    t_ctl(1'b1);
    t_dat(1'b1, 16'hA5A5);
    t_ctl(1'b0);
    t_dat(1'b0, 16'h5A5A);
    t_stall_and_pending_ctl();
    t_sequence();
    t_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule